// File: doc/BRIEF.md
# Split-Size Translation Cache with Protected-Page Flush

This block is a small, fully associative cache of address translations. It maps a 32-bit linear address to a 32-bit physical address. There are two independent entry arrays. One holds 4 KB page translations, tagged by linear bits [31:12]. The other holds 4 MB page translations, tagged by linear bits [31:22]. A combinational lookup port reports a hit and returns the physical address: the cached frame number followed by the untranslated page offset. A page walker installs new translations through a fill port. Each array replaces its entries round-robin.

Three control inputs model the events that affect cached translations:

- `base_load` is a pulse for a load of the page-directory base register, whether from an explicit write or from a task switch. It discards cached translations.
- `gpe` is the global-page enable level. While it is high, entries that were filled with the protect flag survive a base load.
- `inv_en` with `inv_addr` is a single-page invalidate. It removes whichever entries map that one address, in either array, protected or not.

Top module: `tlb_gflush`

## Requirements
- R1: After reset every entry is invalid: every lookup misses, `lk_hit`=0, `lk_large`=0 and `lk_pa`=0.
- R2: A small fill (`fill_large`=0) of `fill_addr` makes lookups in the same 4 KB page hit from the next cycle. The result is `lk_pa` = {`fill_pa`[31:12], `lk_addr`[11:0]} with `lk_large`=0. Addresses in other pages still miss.
- R3: A large fill (`fill_large`=1) makes lookups in the same 4 MB region hit from the next cycle. The result is `lk_pa` = {`fill_pa`[31:22], `lk_addr`[21:0]} with `lk_large`=1.
- R4: When both arrays hit, the large-page entry supplies `lk_pa` and `lk_large`=1.
- R5: A fill whose tag is already cached in its array overwrites that entry. It does not allocate a second slot and does not advance the replacement pointer.
- R6: Each array allocates round-robin, starting at slot 0 after reset. After DEPTH+1 distinct fills, the first translation is gone and the others remain.
- R7: A base load while `gpe`=0 invalidates every entry in both arrays, including protected ones.
- R8: A base load while `gpe`=1 keeps exactly the entries filled with `fill_global`=1 and invalidates all others.
- R9: An invalidate clears, in both arrays, the entries whose tag matches `inv_addr`, including protected ones. All other entries stay valid.
- R10: When a base load and a fill occur in the same cycle, the fill is dropped.
- R11: Small and large translations occupy separate arrays, so filling one size never evicts the other size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| lk_addr | input | 32 | Linear address to translate |
| lk_hit | output | 1 | Lookup hit |
| lk_large | output | 1 | Hit came from the 4 MB array |
| lk_pa | output | 32 | Translated physical address (0 on miss) |
| fill_en | input | 1 | Install a translation |
| fill_large | input | 1 | 1 = 4 MB page, 0 = 4 KB page |
| fill_addr | input | 32 | Linear address of the page being filled |
| fill_pa | input | 32 | Physical address of the page; frame bits are taken from it |
| fill_global | input | 1 | Protect flag for the new entry |
| base_load | input | 1 | Directory base load event (flush) |
| gpe | input | 1 | Global-page protection enable |
| inv_en | input | 1 | Single-page invalidate |
| inv_addr | input | 32 | Linear address to invalidate |

## Verification
The hardest situations to reach from the ports are those that depend on hidden replacement state or on collisions between events.

- **Overwrite versus allocate.** Refilling a tag must not move the round-robin pointer. This only becomes visible several fills later, when a translation that should still be present either remains or is evicted. The stimulus refills one page and then supplies exactly DEPTH-1 new pages.
- **Cross-array interactions.** These are reached by deliberately placing a 4 MB translation over an already cached 4 KB page. Lookup priority and the two-array invalidate are then checked at the same address.
- **Collisions.** A fill is issued in the same cycle as a protected-page flush, so the dropped fill is visible even though its protect flag would otherwise have let it survive.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int SMALL_SHIFT = 12;
  localparam int LARGE_SHIFT = 22;

  function automatic int ptr_bits(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/tlb_set.sv
module tlb_set #(
  parameter int TAG_W = 20,
  parameter int FRM_W = 20,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  output logic [FRM_W-1:0] lk_frame,
  input  logic             fill_en,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [FRM_W-1:0] fill_frame,
  input  logic             fill_glob,
  input  logic             flush,
  input  logic             keep_glob,
  input  logic             inv_en,
  input  logic [TAG_W-1:0] inv_tag
);
  localparam int PTR_W = tlb_pkg::ptr_bits(DEPTH);

  logic [DEPTH-1:0]            valid_q, valid_d, glob_q, glob_d, wr_en;
  logic [DEPTH-1:0][TAG_W-1:0] tag_q, tag_d;
  logic [DEPTH-1:0][FRM_W-1:0] frm_q;
  logic [PTR_W-1:0]            ptr_q, ptr_d;
  logic [DEPTH-1:0]            lk_match, fill_match;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_cmp
      assign lk_match[g]   = valid_q[g] && (tag_q[g] == lk_tag);
      assign fill_match[g] = valid_q[g] && (tag_q[g] == fill_tag);
    end
  endgenerate

  always_comb begin
    lk_frame = '0;
    for (int i = 0; i < DEPTH; i++)
      if (lk_match[i]) lk_frame = lk_frame | frm_q[i];
  end
  assign lk_hit = |lk_match;

  always_comb begin
    logic [PTR_W-1:0] sel;
    valid_d = valid_q;
    glob_d  = glob_q;
    tag_d   = tag_q;
    ptr_d   = ptr_q;
    wr_en   = '0;
    sel     = ptr_q;
    if (flush) begin
      valid_d = valid_q & glob_q & {DEPTH{keep_glob}};
    end else if (fill_en) begin
      if (|fill_match) begin
        for (int i = 0; i < DEPTH; i++)
          if (fill_match[i]) sel = PTR_W'(i);
      end else begin
        ptr_d = (ptr_q == PTR_W'(DEPTH-1)) ? '0 : ptr_q + 1'b1;
      end
      wr_en[sel]   = 1'b1;
      valid_d[sel] = 1'b1;
      glob_d[sel]  = fill_glob;
      tag_d[sel]   = fill_tag;
    end
    if (inv_en)
      for (int i = 0; i < DEPTH; i++)
        if (tag_d[i] == inv_tag) valid_d[i] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      ptr_q   <= '0;
    end else begin
      valid_q <= valid_d;
      ptr_q   <= ptr_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++)
      if (wr_en[i]) begin
        tag_q[i] <= tag_d[i];
        glob_q[i] <= glob_d[i];
        frm_q[i] <= fill_frame;
      end
  end

  // R5
  one_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));

  // R8
  keep_only_glob_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> ((valid_q & ~glob_q) == '0));
endmodule

// File: rtl/tlb_gflush.sv
module tlb_gflush #(
  parameter int VA_W        = 32,
  parameter int PA_W        = 32,
  parameter int SMALL_DEPTH = 4,
  parameter int LARGE_DEPTH = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [VA_W-1:0] lk_addr,
  output logic            lk_hit,
  output logic            lk_large,
  output logic [PA_W-1:0] lk_pa,
  input  logic            fill_en,
  input  logic            fill_large,
  input  logic [VA_W-1:0] fill_addr,
  input  logic [PA_W-1:0] fill_pa,
  input  logic            fill_global,
  input  logic            base_load,
  input  logic            gpe,
  input  logic            inv_en,
  input  logic [VA_W-1:0] inv_addr
);
  localparam int SS   = tlb_pkg::SMALL_SHIFT;
  localparam int LS   = tlb_pkg::LARGE_SHIFT;
  localparam int ST_W = VA_W - SS;
  localparam int LT_W = VA_W - LS;
  localparam int SF_W = PA_W - SS;
  localparam int LF_W = PA_W - LS;

  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  logic            s_hit, l_hit;
  logic [SF_W-1:0] s_frame;
  logic [LF_W-1:0] l_frame;

  tlb_set #(.TAG_W(ST_W), .FRM_W(SF_W), .DEPTH(SMALL_DEPTH)) u_small (
    .clk, .rst_n(rst_i),
    .lk_tag(lk_addr[VA_W-1:SS]), .lk_hit(s_hit), .lk_frame(s_frame),
    .fill_en(fill_en && !fill_large), .fill_tag(fill_addr[VA_W-1:SS]),
    .fill_frame(fill_pa[PA_W-1:SS]), .fill_glob(fill_global),
    .flush(base_load), .keep_glob(gpe),
    .inv_en, .inv_tag(inv_addr[VA_W-1:SS])
  );

  tlb_set #(.TAG_W(LT_W), .FRM_W(LF_W), .DEPTH(LARGE_DEPTH)) u_large (
    .clk, .rst_n(rst_i),
    .lk_tag(lk_addr[VA_W-1:LS]), .lk_hit(l_hit), .lk_frame(l_frame),
    .fill_en(fill_en && fill_large), .fill_tag(fill_addr[VA_W-1:LS]),
    .fill_frame(fill_pa[PA_W-1:LS]), .fill_glob(fill_global),
    .flush(base_load), .keep_glob(gpe),
    .inv_en, .inv_tag(inv_addr[VA_W-1:LS])
  );

  always_comb begin
    lk_hit   = s_hit || l_hit;
    lk_large = l_hit;
    if (l_hit)      lk_pa = {l_frame, lk_addr[LS-1:0]};
    else if (s_hit) lk_pa = {s_frame, lk_addr[SS-1:0]};
    else            lk_pa = '0;
  end

  // R7
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (base_load && !gpe) |=> !lk_hit);

  // R9
  inv_miss_chk: assert property (@(posedge clk) disable iff (!rst_i)
    inv_en |=> ((lk_addr != $past(inv_addr)) || !lk_hit));

  // R2
  fill_hit_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (fill_en && !base_load && !inv_en) |=> ((lk_addr != $past(fill_addr)) || lk_hit));
endmodule

// File: tb/tlb_gflush_tb.sv
module tlb_gflush_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] lk_addr, fill_addr, fill_pa, inv_addr, lk_pa;
  logic        lk_hit, lk_large, fill_en, fill_large, fill_global, base_load, gpe, inv_en;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  tlb_gflush u_dut (
    .clk, .rst_n, .lk_addr, .lk_hit, .lk_large, .lk_pa,
    .fill_en, .fill_large, .fill_addr, .fill_pa, .fill_global,
    .base_load, .gpe, .inv_en, .inv_addr
  );

  task automatic look(string req, logic [31:0] a, bit eh, bit el, logic [31:0] ep);
    lk_addr = a;
    #1;
    checks++;
    if (lk_hit !== eh || lk_large !== el || lk_pa !== ep) begin
      errors++;
      $display("FAIL %s addr=%h got hit=%b large=%b pa=%h exp hit=%b large=%b pa=%h",
               req, a, lk_hit, lk_large, lk_pa, eh, el, ep);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    fill_en = 0; base_load = 0; inv_en = 0;
  endtask

  task automatic fill(bit lg, logic [31:0] va, logic [31:0] pa, bit gl);
    fill_en = 1; fill_large = lg; fill_addr = va; fill_pa = pa; fill_global = gl;
    step();
  endtask

  task automatic do_reset();
    fill_en = 0; base_load = 0; inv_en = 0; gpe = 0;
    fill_large = 0; fill_addr = 0; fill_pa = 0; fill_global = 0; inv_addr = 0; lk_addr = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] sva(int i); return 32'h1000_0000 + i * 32'h3000; endfunction
  function automatic logic [31:0] spa(int i); return (32'hA000_0 + i * 13) << 12; endfunction
  function automatic logic [31:0] lva(int j); return 32'h4000_0000 + (j << 22); endfunction
  function automatic logic [31:0] lpa(int j); return (32'h200 + j * 5) << 22; endfunction

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000) begin
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [11:0] offs[3] = '{12'h000, 12'hFFF, 12'h5A5};
    do_reset();
    // R1: nothing cached after reset
    for (int i = 0; i < 6; i++) look("R1", sva(i) + 32'h123, 0, 0, 0);
    look("R1", lva(0), 0, 0, 0);

    // R2: small fills, sweep offsets
    for (int i = 0; i < 4; i++) fill(0, sva(i), spa(i), 0);
    for (int i = 0; i < 4; i++) begin
      foreach (offs[k]) look("R2", sva(i) | offs[k], 1, 0, spa(i) | offs[k]);
      look("R2", sva(i) + 32'h1000, 0, 0, 0);
    end
    // R6: fifth fill evicts slot 0
    fill(0, sva(4), spa(4), 0);
    look("R6", sva(0), 0, 0, 0);
    for (int i = 1; i < 5; i++) look("R6", sva(i) + 7, 1, 0, spa(i) + 7);
    // R3 + R11: large fills leave small entries alone
    for (int j = 0; j < 2; j++) fill(1, lva(j), lpa(j), 0);
    for (int j = 0; j < 2; j++) begin
      look("R3", lva(j), 1, 1, lpa(j));
      look("R3", lva(j) + 32'h3F_FFFF, 1, 1, lpa(j) + 32'h3F_FFFF);
    end
    for (int i = 1; i < 5; i++) look("R11", sva(i), 1, 0, spa(i));
    // R4: large page over cached small page wins; R6 evicts large slot 0
    fill(1, 32'h1000_0000, lpa(7), 0);
    look("R6", lva(0), 0, 0, 0);
    look("R4", sva(1) + 32'h10, 1, 1, lpa(7) + sva(1)[21:0] + 32'h10);

    // R5: overwrite does not allocate
    do_reset();
    fill(0, sva(0), spa(0), 0);
    fill(0, sva(0), spa(9), 0);
    for (int i = 1; i < 4; i++) fill(0, sva(i), spa(i), 0);
    look("R5", sva(0) + 4, 1, 0, spa(9) + 4);
    for (int i = 1; i < 4; i++) look("R5", sva(i), 1, 0, spa(i));

    // R7: flush with protection off
    do_reset();
    fill(0, sva(0), spa(0), 1);
    fill(0, sva(1), spa(1), 0);
    fill(1, lva(0), lpa(0), 1);
    gpe = 0; base_load = 1; step();
    look("R7", sva(0), 0, 0, 0);
    look("R7", sva(1), 0, 0, 0);
    look("R7", lva(0), 0, 0, 0);

    // R8: flush with protection on
    do_reset();
    fill(0, sva(0), spa(0), 1);
    fill(0, sva(1), spa(1), 0);
    fill(1, lva(0), lpa(0), 1);
    fill(1, lva(1), lpa(1), 0);
    gpe = 1; base_load = 1; step();
    look("R8", sva(0), 1, 0, spa(0));
    look("R8", sva(1), 0, 0, 0);
    look("R8", lva(0), 1, 1, lpa(0));
    look("R8", lva(1), 0, 0, 0);

    // R9: invalidate clears both arrays, protected too
    do_reset();
    fill(0, sva(0), spa(0), 1);
    fill(0, sva(1), spa(1), 0);
    fill(1, 32'h1000_0000, lpa(3), 1);
    fill(1, lva(1), lpa(1), 0);
    inv_en = 1; inv_addr = sva(0) + 32'h44; step();
    look("R9", sva(0), 0, 0, 0);
    look("R9", lva(1), 1, 1, lpa(1));
    inv_en = 1; inv_addr = sva(1); step();
    look("R9", sva(1), 0, 0, 0);
    look("R9", lva(1) + 9, 1, 1, lpa(1) + 9);

    // R10: fill dropped under flush
    do_reset();
    fill(0, sva(0), spa(0), 0);
    gpe = 1; base_load = 1;
    fill_en = 1; fill_large = 0; fill_addr = sva(2); fill_pa = spa(2); fill_global = 1;
    step();
    look("R10", sva(2), 0, 0, 0);
    look("R10", sva(0), 0, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule